// File: doc/BRIEF.md
# Monochrome Glyph Expansion Blitter

This drawing engine turns 1-bit-per-pixel bitmap words into 8-bit pixel writes into a framebuffer. Software first programs the foreground and background colours, a plane mask, the target row, the start column and the inclusive end column. Writing a 32-bit glyph word then starts the drawing. Each bit becomes one pixel, taken from the most significant bit downward. A set bit writes the foreground colour and a clear bit writes the background colour. The engine emits one pixel write per clock on a simple write port that carries per-bit write enables.

The glyph write also moves the start column and the row by two increment registers. A run of glyph words can therefore walk across a line of text with no further programming. All drawing parameters are captured when a glyph word is accepted, so software may reprogram registers while a word is still being drawn. A second glyph word that arrives while the engine is busy waits in a one-deep buffer. While that buffer is occupied the register port deasserts its ready signal. A status word shows the busy state in bit 28, and software polls it.

Top module: `glyph_blit`

## Requirements
- R1: A write accepted at address 8 (the glyph register) starts a job. The first pixel write is presented in the cycle after the accepting clock edge, and the remaining pixels of the word follow on consecutive cycles, one per clock.
- R2: Pixel i of a span (i = 0 is the leftmost) uses glyph bit 31−i. A 1 drives the foreground colour on the data output and a 0 drives the background colour.
- R3: The address of pixel i is y × PITCH + x + i, where x is the start column and y is the row captured for that word.
- R4: The span holds (end − start + 1) pixels. When end − start, taken modulo 2^XW, exceeds 31, the span holds 32 pixels.
- R5: Every pixel write carries the plane mask on the per-bit write-enable output.
- R6: Each accepted glyph word adds the X increment to the start column and the Y increment to the row, both modulo their widths. The next glyph word uses the advanced position unless software rewrites it.
- R7: Colours, mask, position and span are captured when a glyph word is accepted. Register writes made while that word is being drawn do not affect its pixels.
- R8: Status bit 28 is 1 while a word is being drawn or one is waiting in the buffer, and 0 otherwise. All other status bits are 0.
- R9: A glyph word accepted while the engine is drawing is held and drawn immediately after the current word with no idle cycle. While it is held, regReady is 0 and any register write is ignored.
- R10: After reset there are no pixel writes, the status word is 0, regReady is 1, the plane mask is 0xFF, and all other registers are 0.
- R11: The register addresses are: 0 foreground, 1 background, 2 plane mask, 3 start column, 4 row, 5 end column, 6 X increment, 7 Y increment, 8 glyph word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write request |
| regAddr | input | 4 | Register address |
| regWrData | input | 32 | Register write data |
| regReady | output | 1 | A register write is accepted in this cycle |
| statusWord | output | 32 | Status; bit 28 is busy |
| pixWrEn | output | 1 | Pixel write strobe |
| pixAddr | output | AW (24) | Pixel address |
| pixData | output | CW (8) | Pixel colour |
| pixMask | output | CW (8) | Per-bit write enables |

## Verification
A glyph word accepted at a clock edge puts its first pixel on the port in the next cycle, and pixel i appears i cycles after that. A buffered word starts exactly one cycle after the last pixel of the word ahead of it. The status bit and regReady react in the cycle that follows the accepting edge. The bench drives inputs and samples outputs on falling edges. It stamps every observed pixel write with a cycle counter, and it compares those stamps against the acceptance cycle plus the pixel index rather than merely checking order.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

  localparam logic [3:0] REG_FG    = 4'd0;
  localparam logic [3:0] REG_BG    = 4'd1;
  localparam logic [3:0] REG_MASK  = 4'd2;
  localparam logic [3:0] REG_X0    = 4'd3;
  localparam logic [3:0] REG_Y0    = 4'd4;
  localparam logic [3:0] REG_X1    = 4'd5;
  localparam logic [3:0] REG_INCX  = 4'd6;
  localparam logic [3:0] REG_INCY  = 4'd7;
  localparam logic [3:0] REG_GLYPH = 4'd8;

  localparam int GLYPH_BITS = 32;
  localparam int BUSY_BIT   = 28;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic regWe;        // register write accepted
    logic advance;      // glyph accepted: move position
    logic loadActRegs;  // start job from live registers
    logic loadActPend;  // start job from holding buffer
    logic loadPend;     // capture job into holding buffer
    logic step;         // move to next pixel
  } glyph_strobe_t;

endpackage

// File: rtl/glyph_ctrl.sv
module glyph_ctrl
  import glyph_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [3:0]    regAddr,
  input  logic          lastPix,
  output glyph_strobe_t strb,
  output logic          actValid,
  output logic          pendValid
);

  logic glyphWr;
  logic finishing;

  assign glyphWr   = regWrEn && !pendValid && (regAddr == REG_GLYPH);
  assign finishing = actValid && lastPix;

  always_comb begin
    strb         = '0;
    strb.regWe   = regWrEn && !pendValid;
    strb.advance = glyphWr;
    if (!actValid) begin
      strb.loadActRegs = glyphWr;
    end else if (!finishing) begin
      strb.step     = 1'b1;
      strb.loadPend = glyphWr;
    end else if (pendValid) begin
      strb.loadActPend = 1'b1;
    end else begin
      strb.loadActRegs = glyphWr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actValid  <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      if (strb.loadActRegs || strb.loadActPend) actValid <= 1'b1;
      else if (finishing)                       actValid <= 1'b0;
      if (strb.loadPend)         pendValid <= 1'b1;
      else if (strb.loadActPend) pendValid <= 1'b0;
    end
  end

  // R9: a held word stays held until the running word ends
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !finishing) |=> pendValid);

  // R9: the buffer is only ever filled when empty
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPend |-> !pendValid);

  // R9: a held word implies a word in flight
  p_pend_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> actValid);

endmodule

// File: rtl/glyph_dpath.sv
module glyph_dpath
  import glyph_pkg::*;
#(
  parameter int XW    = 12,
  parameter int YW    = 12,
  parameter int AW    = 24,
  parameter int CW    = 8,
  parameter int PITCH = 1024
) (
  input  logic          clk,
  input  logic          rstN,
  input  glyph_strobe_t strb,
  input  logic          actValid,
  input  logic [3:0]    regAddr,
  input  logic [31:0]   regWrData,
  output logic          lastPix,
  output logic [AW-1:0] pixAddr,
  output logic [CW-1:0] pixData,
  output logic [CW-1:0] pixMask
);

  localparam int CNTW = $clog2(GLYPH_BITS);

  typedef struct packed {
    logic [GLYPH_BITS-1:0] word;
    logic [AW-1:0]         addr;
    logic [CW-1:0]         fg;
    logic [CW-1:0]         bg;
    logic [CW-1:0]         mask;
    logic [CNTW-1:0]       last;
  } job_t;

  logic [CW-1:0] fgReg, bgReg, maskReg;
  logic [XW-1:0] x0Reg, x1Reg, incX;
  logic [YW-1:0] y0Reg, incY;

  job_t newJob, actJob, pendJob;
  logic [CNTW-1:0] actCnt;
  logic [XW-1:0]   spanDiff;

  // register file with auto-advance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fgReg   <= '0;
      bgReg   <= '0;
      maskReg <= '1;
      x0Reg   <= '0;
      x1Reg   <= '0;
      y0Reg   <= '0;
      incX    <= '0;
      incY    <= '0;
    end else if (strb.advance) begin
      x0Reg <= x0Reg + incX;
      y0Reg <= y0Reg + incY;
    end else if (strb.regWe) begin
      case (regAddr)
        REG_FG:   fgReg   <= regWrData[CW-1:0];
        REG_BG:   bgReg   <= regWrData[CW-1:0];
        REG_MASK: maskReg <= regWrData[CW-1:0];
        REG_X0:   x0Reg   <= regWrData[XW-1:0];
        REG_Y0:   y0Reg   <= regWrData[YW-1:0];
        REG_X1:   x1Reg   <= regWrData[XW-1:0];
        REG_INCX: incX    <= regWrData[XW-1:0];
        REG_INCY: incY    <= regWrData[YW-1:0];
        default: ;
      endcase
    end
  end

  // job snapshot from live registers
  always_comb begin
    spanDiff    = x1Reg - x0Reg;
    newJob.word = regWrData;
    newJob.addr = AW'(y0Reg) * AW'(PITCH) + AW'(x0Reg);
    newJob.fg   = fgReg;
    newJob.bg   = bgReg;
    newJob.mask = maskReg;
    newJob.last = (spanDiff > XW'(GLYPH_BITS - 1)) ? CNTW'(GLYPH_BITS - 1)
                                                   : spanDiff[CNTW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendJob <= '0;
    end else if (strb.loadPend) begin
      pendJob <= newJob;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actJob <= '0;
      actCnt <= '0;
    end else if (strb.loadActRegs) begin
      actJob <= newJob;
      actCnt <= '0;
    end else if (strb.loadActPend) begin
      actJob <= pendJob;
      actCnt <= '0;
    end else if (strb.step) begin
      actJob.word <= {actJob.word[GLYPH_BITS-2:0], 1'b0};
      actJob.addr <= actJob.addr + AW'(1);
      actCnt      <= actCnt + CNTW'(1);
    end
  end

  assign lastPix = (actCnt == actJob.last);
  assign pixAddr = actJob.addr;
  assign pixData = actJob.word[GLYPH_BITS-1] ? actJob.fg : actJob.bg;
  assign pixMask = actJob.mask;

  // R4: the sequencer never steps beyond the last pixel of a span
  p_span_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> !lastPix);

  // R4: the pixel index stays inside the captured span
  p_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    actValid |-> (actCnt <= actJob.last));

endmodule

// File: rtl/glyph_blit.sv
module glyph_blit
  import glyph_pkg::*;
#(
  parameter int XW    = 12,
  parameter int YW    = 12,
  parameter int AW    = 24,
  parameter int CW    = 8,
  parameter int PITCH = 1024
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [3:0]    regAddr,
  input  logic [31:0]   regWrData,
  output logic          regReady,
  output logic [31:0]   statusWord,
  output logic          pixWrEn,
  output logic [AW-1:0] pixAddr,
  output logic [CW-1:0] pixData,
  output logic [CW-1:0] pixMask
);

  glyph_strobe_t strb;
  logic actValid, pendValid, lastPix;

  glyph_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .lastPix   (lastPix),
    .strb      (strb),
    .actValid  (actValid),
    .pendValid (pendValid)
  );

  glyph_dpath #(
    .XW(XW), .YW(YW), .AW(AW), .CW(CW), .PITCH(PITCH)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .actValid  (actValid),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .lastPix   (lastPix),
    .pixAddr   (pixAddr),
    .pixData   (pixData),
    .pixMask   (pixMask)
  );

  always_comb begin
    statusWord           = '0;
    statusWord[BUSY_BIT] = actValid || pendValid;
  end

  assign regReady = !pendValid;
  assign pixWrEn  = actValid;

  // R1: drawing only starts from an accepted glyph write
  p_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pixWrEn) |-> $past(regWrEn && regReady && (regAddr == REG_GLYPH)));

  // R8: pixel writes only while status shows busy
  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    pixWrEn |-> statusWord[BUSY_BIT]);

  // R9: back-pressure only while a word is in flight
  p_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regReady |-> (pixWrEn && statusWord[BUSY_BIT]));

endmodule

// File: tb/glyph_blit_tb_top.sv
module glyph_blit_tb_top;

  localparam int PITCH = 1024;
  localparam int AW    = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        regReady;
  logic [31:0] statusWord;
  logic        pixWrEn;
  logic [AW-1:0] pixAddr;
  logic [7:0]  pixData, pixMask;

  always #2 clk = ~clk;  // 250 MHz

  glyph_blit #(.PITCH(PITCH), .AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regReady(regReady), .statusWord(statusWord),
    .pixWrEn(pixWrEn), .pixAddr(pixAddr), .pixData(pixData), .pixMask(pixMask)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int acceptCyc;

  always @(posedge clk) cyc <= cyc + 1;

  // capture of pixel writes
  int          nCap = 0;
  logic [AW-1:0] capAddr [512];
  logic [7:0]  capData [512];
  logic [7:0]  capMask [512];
  int          capCyc  [512];

  always @(negedge clk) begin
    if (rstN && pixWrEn && nCap < 512) begin
      capAddr[nCap] = pixAddr;
      capData[nCap] = pixData;
      capMask[nCap] = pixMask;
      capCyc[nCap]  = cyc;
      nCap = nCap + 1;
    end
  end

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    while (!regReady) @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    acceptCyc = cyc;
    regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (statusWord[28]) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int spanOf(input int x0, input int x1);
    int d;
    d = (x1 - x0) & 12'hFFF;
    return (d > 31) ? 32 : d + 1;
  endfunction

  // compare one word's pixels starting at capture index base
  task automatic checkWord(input int base, input int x0, input int y0, input int w,
                           input logic [31:0] word, input logic [7:0] fg,
                           input logic [7:0] bg, input logic [7:0] mask,
                           input int startCyc, input string req);
    bit ok = 1'b1;
    longint act = 0, exp = 0;
    for (int i = 0; i < w; i++) begin
      logic [AW-1:0] eAddr;
      logic [7:0] eData;
      eAddr = AW'(y0 * PITCH + x0 + i);
      eData = word[31 - i] ? fg : bg;
      if (ok && (capAddr[base+i] !== eAddr)) begin ok = 0; act = capAddr[base+i]; exp = eAddr; end
      if (ok && (capData[base+i] !== eData)) begin ok = 0; act = capData[base+i]; exp = eData; end
      if (ok && (capMask[base+i] !== mask))  begin ok = 0; act = capMask[base+i]; exp = mask; end
      if (ok && (capCyc[base+i] != startCyc + i)) begin ok = 0; act = capCyc[base+i]; exp = startCyc + i; end
    end
    check(ok, req, act, exp);
  endtask

  // {x0, x1, y0, word, fg, bg}
  localparam logic [83:0] VEC [6] = '{
    {12'd0,   12'd31,  12'd0,  32'hA5A5_0F0F, 8'hFF, 8'h00},
    {12'd100, 12'd107, 12'd3,  32'h8100_0000, 8'h12, 8'h34},
    {12'd5,   12'd5,   12'd7,  32'h8000_0000, 8'hAA, 8'h55},
    {12'd200, 12'd215, 12'd20, 32'hF0F0_1234, 8'h0C, 8'hC0},
    {12'd10,  12'd9,   12'd1,  32'hDEAD_BEEF, 8'h77, 8'h88},
    {12'd40,  12'd100, 12'd2,  32'h0000_FFFF, 8'h5A, 8'hA5}
  };

  initial begin
    repeat (100000) @(negedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state at the ports
    check(pixWrEn == 1'b0, "R10 pixWrEn", pixWrEn, 0);
    check(statusWord == 32'h0, "R10 status", statusWord, 0);
    check(regReady == 1'b1, "R10 ready", regReady, 1);

    // R10: plane mask resets to 0xFF (first word drawn before mask write)
    wr(4'd0, 32'h11); wr(4'd1, 32'h22); wr(4'd3, 32'd8); wr(4'd4, 32'd9);
    wr(4'd5, 32'd9);
    nCap = 0;
    wr(4'd8, 32'hC000_0000);
    waitIdle();
    checkWord(0, 8, 9, 2, 32'hC000_0000, 8'h11, 8'h22, 8'hFF, acceptCyc, "R10 mask reset");

    // table walk: R1 R2 R3 R4 R5 R11
    wr(4'd2, 32'hFF);
    for (int v = 0; v < 6; v++) begin
      logic [83:0] e;
      int w;
      e = VEC[v];
      w = spanOf(int'(e[83:72]), int'(e[71:60]));
      wr(4'd0, {24'd0, e[15:8]});
      wr(4'd1, {24'd0, e[7:0]});
      wr(4'd3, {20'd0, e[83:72]});
      wr(4'd4, {20'd0, e[59:48]});
      wr(4'd5, {20'd0, e[71:60]});
      nCap = 0;
      wr(4'd8, e[47:16]);
      check(statusWord == 32'h1000_0000, "R8 busy", statusWord, 32'h1000_0000);
      waitIdle();
      check(nCap == w, "R4 span count", nCap, w);
      checkWord(0, int'(e[83:72]), int'(e[59:48]), w, e[47:16], e[15:8], e[7:0],
                8'hFF, acceptCyc, "R1 R2 R3 R5 pixels");
    end
    check(statusWord == 32'h0, "R8 idle", statusWord, 0);

    // R6: auto-advance of start column and row
    wr(4'd6, 32'd32); wr(4'd7, 32'd2);
    wr(4'd3, 32'd64); wr(4'd4, 32'd5); wr(4'd5, 32'd95);
    wr(4'd8, 32'hFFFF_0000);
    waitIdle();
    wr(4'd5, 32'd127);
    nCap = 0;
    wr(4'd8, 32'h0F0F_0F0F);
    waitIdle();
    check(nCap == 32, "R6 advanced span", nCap, 32);
    check(capAddr[0] == AW'(7 * PITCH + 96), "R6 advanced addr", capAddr[0], 7 * PITCH + 96);

    // R7 / R9: snapshot, held word, back-pressure
    wr(4'd7, 32'd1);
    wr(4'd2, 32'h0F); wr(4'd0, 32'hE1); wr(4'd1, 32'h1E);
    wr(4'd3, 32'd20); wr(4'd4, 32'd10); wr(4'd5, 32'd27);
    nCap = 0;
    wr(4'd8, 32'hB400_0000);
    begin
      int aCyc;
      aCyc = acceptCyc;
      wr(4'd0, 32'h3C);
      wr(4'd3, 32'd300);
      wr(4'd5, 32'd303);
      wr(4'd8, 32'h9000_0000);
      check(regReady == 1'b0, "R9 ready low", regReady, 0);
      // attempted write while held: must be ignored
      regWrEn = 1'b1; regAddr = 4'd0; regWrData = 32'h77;
      @(negedge clk);
      regWrEn = 1'b0;
      waitIdle();
      check(nCap == 12, "R9 total pixels", nCap, 12);
      checkWord(0, 20, 10, 8, 32'hB400_0000, 8'hE1, 8'h1E, 8'h0F, aCyc, "R7 first word");
      checkWord(8, 300, 11, 4, 32'h9000_0000, 8'h3C, 8'h1E, 8'h0F, aCyc + 8, "R9 held word");
    end

    // R9: ignored write left the foreground unchanged
    wr(4'd3, 32'd0); wr(4'd4, 32'd0); wr(4'd5, 32'd0);
    nCap = 0;
    wr(4'd8, 32'h8000_0000);
    waitIdle();
    check(capData[0] == 8'h3C, "R9 ignored write", capData[0], 8'h3C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule